// File: doc/BRIEF.md
# Table-Coded Clock-Enable Divider

This block divides a reference clock by a ratio chosen through a small select code and produces a clock-enable pulse. It does not produce a clock. The code is not used as a count. A fixed lookup table turns it into a division ratio, and the ratios in a table are neither consecutive nor linear in the code. A parameter picks one of six tables. Some tables use every code of a small field. Others accept only a few scattered codes.

The enable output is high for exactly one reference cycle and repeats every N reference cycles, where N is the ratio in force. A new code is presented together with a one-cycle load strobe. It is registered as pending and adopted only at the next period boundary, so no period is ever cut short or stretched. If a code is not in the selected table, the load is ignored, the ratio stays as it was, and a one-cycle error flag is raised.

Top module: `tabdiv_clk_en`

## Requirements
- R1: While reset is held and in the first cycle after it, `tick_o` and `bad_code_o` are 0. After reset, the ratio in force is the ratio of the numerically lowest legal code of the selected table.
- R2: `tick_o` is high for exactly one cycle and low in the cycle that follows. Consecutive pulses are exactly N cycles apart, odd N (9, 11, 13, 15) included.
- R3: With `TABLE_SEL`=0, codes 0, 1, 2 and 3 select ratios 8, 9, 10 and 15. All other codes are illegal.
- R4: With `TABLE_SEL`=1, code c in 0..3 selects ratio 8*(c+1). All other codes are illegal.
- R5: With `TABLE_SEL`=2, code 3 selects ratio 4, code 4 selects 5, code 5 selects 6 and code 7 selects 8. Codes 0, 1, 2, 6 and 8 and above are illegal.
- R6: With `TABLE_SEL`=3, code c in 0..5 selects ratio 9+c, code 6 selects 16 and code 7 selects 18. Codes 8 and above are illegal.
- R7: With `TABLE_SEL`=4, code 7 selects ratio 8 and code 15 selects 16. With `TABLE_SEL`=5, code 15 selects ratio 16 and code 31 selects 32. No other codes are legal in these two tables.
- R8: A load of an illegal code leaves the current ratio unchanged and does not cancel a legal pending load. It raises `bad_code_o` for exactly the one cycle after the strobe.
- R9: A legal load made between pulses does not change the length of the period in progress. The new ratio governs the period that starts after that period's pulse.
- R10: A legal load presented in the same cycle as a pulse takes effect in the period that begins right after that pulse.
- R11: When several legal loads arrive within one period, the last one is the ratio applied at the boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | CODE_W (5) | Select code, sampled when `load_i` is high |
| load_i | input | 1 | One-cycle strobe that requests the code on `code_i` |
| tick_o | output | 1 | One-cycle enable pulse, once every N cycles |
| bad_code_o | output | 1 | One-cycle flag that a loaded code was not in the table |

## Verification
The bench measures the spacing of pulses for every legal code of all six tables. A table entry that is wrong, or an off-by-one terminal count, shows up as a period one cycle short or long, and odd ratios catch a counter that only works for even ratios. It places loads in the middle of a period, in the pulse cycle itself, and twice back to back. A design that switches ratios at once would produce a truncated period, and one that takes the first load instead of the last would settle on the wrong ratio. Illegal codes are loaded after a legal pending load. A design that treated them as ratio 0, or cleared the pending request, would stall or keep the old ratio, and a stuck or missing error pulse is seen at the port.

// File: rtl/tabdiv_pkg.sv
package tabdiv_pkg;

  localparam int unsigned NUM_TABLES = 6;

  // Ratio for a code in a given table; 0 marks an illegal code.
  function automatic int unsigned code_ratio(input int unsigned sel, input int unsigned code);
    int unsigned r;
    r = 0;
    case (sel)
      0: case (code)
           0: r = 8;  1: r = 9;  2: r = 10; 3: r = 15;
           default: r = 0;
         endcase
      1: case (code)
           0: r = 8;  1: r = 16; 2: r = 24; 3: r = 32;
           default: r = 0;
         endcase
      2: case (code)
           3: r = 4;  4: r = 5;  5: r = 6;  7: r = 8;
           default: r = 0;
         endcase
      3: case (code)
           0: r = 9;  1: r = 10; 2: r = 11; 3: r = 12;
           4: r = 13; 5: r = 14; 6: r = 16; 7: r = 18;
           default: r = 0;
         endcase
      4: case (code)
           7: r = 8;  15: r = 16;
           default: r = 0;
         endcase
      5: case (code)
           15: r = 16; 31: r = 32;
           default: r = 0;
         endcase
      default: r = 0;
    endcase
    return r;
  endfunction

  // Ratio of the numerically lowest legal code.
  function automatic int unsigned lowest_ratio(input int unsigned sel, input int unsigned code_w);
    int unsigned r;
    r = 0;
    for (int c = (1 << code_w) - 1; c >= 0; c--) begin
      if (code_ratio(sel, c) != 0) r = code_ratio(sel, c);
    end
    return r;
  endfunction

endpackage

// File: rtl/tabdiv_code_map.sv
module tabdiv_code_map #(
  parameter int unsigned TABLE_SEL = 3,
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned RATIO_W   = 6
) (
  input  logic [CODE_W-1:0]  code_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               legal_o
);
  logic [31:0] lookup;

  always_comb begin
    lookup  = tabdiv_pkg::code_ratio(TABLE_SEL, 32'(code_i));
    ratio_o = lookup[RATIO_W-1:0];
    legal_o = (lookup != 32'd0);
  end
endmodule

// File: rtl/tabdiv_ratio_reg.sv
module tabdiv_ratio_reg #(
  parameter int unsigned RATIO_W     = 6,
  parameter int unsigned RESET_RATIO = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               legal_i,
  input  logic [RATIO_W-1:0] new_ratio_i,
  input  logic               boundary_i,
  output logic [RATIO_W-1:0] cur_ratio_o,
  output logic               pend_valid_o,
  output logic               bad_o
);
  logic [RATIO_W-1:0] pend_ratio_q;
  logic               take_new;

  assign take_new = load_i & legal_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_ratio_o  <= RATIO_W'(RESET_RATIO);
      pend_ratio_q <= RATIO_W'(RESET_RATIO);
      pend_valid_o <= 1'b0;
      bad_o        <= 1'b0;
    end else begin
      bad_o <= load_i & ~legal_i;
      if (boundary_i) begin
        if (take_new)          cur_ratio_o <= new_ratio_i;
        else if (pend_valid_o) cur_ratio_o <= pend_ratio_q;
        pend_valid_o <= 1'b0;
      end else if (take_new) begin
        pend_ratio_q <= new_ratio_i;
        pend_valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tabdiv_period_ctr.sv
module tabdiv_period_ctr #(
  parameter int unsigned RATIO_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [RATIO_W-1:0] cnt_o,
  output logic               last_o
);
  assign last_o = (cnt_o == ratio_i - RATIO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (last_o) cnt_o <= '0;
    else             cnt_o <= cnt_o + RATIO_W'(1);
  end
endmodule

// File: rtl/tabdiv_clk_en.sv
module tabdiv_clk_en #(
  parameter int unsigned TABLE_SEL = 3,
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned RATIO_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              load_i,
  output logic              tick_o,
  output logic              bad_code_o
);
  localparam int unsigned RESET_RATIO = tabdiv_pkg::lowest_ratio(TABLE_SEL, CODE_W);

  logic [RATIO_W-1:0] map_ratio;
  logic               code_legal;
  logic [RATIO_W-1:0] cur_ratio;
  logic [RATIO_W-1:0] cnt_q;
  logic               pend_valid;
  logic               period_end;

  tabdiv_code_map #(
    .TABLE_SEL(TABLE_SEL), .CODE_W(CODE_W), .RATIO_W(RATIO_W)
  ) u_map (
    .code_i (code_i),
    .ratio_o(map_ratio),
    .legal_o(code_legal)
  );

  tabdiv_ratio_reg #(
    .RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)
  ) u_ratio (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .legal_i     (code_legal),
    .new_ratio_i (map_ratio),
    .boundary_i  (period_end),
    .cur_ratio_o (cur_ratio),
    .pend_valid_o(pend_valid),
    .bad_o       (bad_code_o)
  );

  tabdiv_period_ctr #(
    .RATIO_W(RATIO_W)
  ) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ratio_i(cur_ratio),
    .cnt_o  (cnt_q),
    .last_o (period_end)
  );

  assign tick_o = period_end;
endmodule

// File: rtl/tabdiv_clk_en_chk.sv
module tabdiv_clk_en_chk #(
  parameter int unsigned RATIO_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic               code_legal,
  input logic [RATIO_W-1:0] map_ratio,
  input logic [RATIO_W-1:0] cur_ratio,
  input logic [RATIO_W-1:0] cnt_q,
  input logic               pend_valid,
  input logic               tick_o,
  input logic               bad_code_o
);
  assert_ratio_nonzero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_ratio >= RATIO_W'(2));

  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> cnt_q == $past(cnt_q) + RATIO_W'(1));

  assert_count_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == '0);

  assert_flag_raise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !code_legal) |=> bad_code_o);

  assert_flag_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && !code_legal) |=> !bad_code_o);

  assert_hold_mid_period_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(cur_ratio));

  assert_pending_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && load_i && code_legal) |=> pend_valid);

  assert_apply_at_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && load_i && code_legal) |=> cur_ratio == $past(map_ratio));
endmodule

bind tabdiv_clk_en tabdiv_clk_en_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .code_legal(code_legal),
  .map_ratio (map_ratio),
  .cur_ratio (cur_ratio),
  .cnt_q     (cnt_q),
  .pend_valid(pend_valid),
  .tick_o    (tick_o),
  .bad_code_o(bad_code_o)
);

// File: tb/tabdiv_clk_en_bench.sv
`timescale 1ns/1ps
module tabdiv_clk_en_bench;
  localparam int NV = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    code = '0;
  logic          load = 1'b0;
  logic [NV-1:0] ticks;
  logic [NV-1:0] bads;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  for (genvar v = 0; v < NV; v++) begin : g_var
    tabdiv_clk_en #(.TABLE_SEL(v)) u_tabdiv_clk_en (
      .clk_i(clk), .rst_ni(rst_n), .code_i(code), .load_i(load),
      .tick_o(ticks[v]), .bad_code_o(bads[v])
    );
  end

  // Expected ratio per requirement text; 0 = illegal.
  function automatic int exp_ratio(int v, int c);
    case (v)
      0: return (c >= 0 && c <= 2) ? 8 + c : (c == 3 ? 15 : 0);
      1: return (c >= 0 && c <= 3) ? 8 * (c + 1) : 0;
      2: return (c == 7) ? 8 : ((c >= 3 && c <= 5) ? c + 1 : 0);
      3: return (c <= 5) ? 9 + c : ((c == 6 || c == 7) ? 16 + 2 * (c - 6) : 0);
      4: return (c == 7) ? 8 : (c == 15 ? 16 : 0);
      5: return (c == 15) ? 16 : (c == 31 ? 32 : 0);
      default: return 0;
    endcase
  endfunction

  function automatic int exp_reset(int v);
    for (int c = 0; c < 32; c++) if (exp_ratio(v, c) != 0) return c * 0 + exp_ratio(v, c);
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input int k);
    @(negedge clk);
    while (!ticks[k]) @(negedge clk);
  endtask

  // Called on a negedge; counts cycles up to the next pulse.
  task automatic run_to_tick(input int k, inout int n);
    do begin
      @(negedge clk);
      n++;
    end while (!ticks[k] && n < 100);
  endtask

  task automatic period(input int k, output int n);
    n = 0;
    run_to_tick(k, n);
  endtask

  task automatic pulse_load(input int c);
    code = 5'(c);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic set_code(input int k, input int c);
    wait_tick(k);
    pulse_load(c);
  endtask

  task automatic measure(input int k, output int n);
    wait_tick(k);
    period(k, n);
  endtask

  task automatic print_summary;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  task automatic test_reset_r1;
    int n;
    repeat (4) @(negedge clk);
    chk(ticks == '0, "R1 tick in reset", int'(ticks), 0);
    chk(bads == '0, "R1 flag in reset", int'(bads), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ticks == '0, "R1 tick after reset", int'(ticks), 0);
    chk(bads == '0, "R1 flag after reset", int'(bads), 0);
    for (int v = 0; v < NV; v++) begin
      measure(v, n);
      chk(n == exp_reset(v), "R1 reset ratio", n, exp_reset(v));
    end
  endtask

  task automatic test_width_r2;
    int n;
    int odd_codes[3] = '{0, 2, 4};
    foreach (odd_codes[i]) begin
      set_code(3, odd_codes[i]);
      wait_tick(3);
      @(negedge clk);
      chk(ticks[3] == 1'b0, "R2 pulse width", int'(ticks[3]), 0);
      n = 1;
      run_to_tick(3, n);
      chk(n == exp_ratio(3, odd_codes[i]), "R2 odd spacing", n, exp_ratio(3, odd_codes[i]));
    end
    set_code(0, 3);
    measure(0, n);
    chk(n == 15, "R2 odd ratio 15", n, 15);
  endtask

  task automatic sweep_table(input int v, input string req);
    int n;
    for (int c = 0; c < 32; c++) begin
      if (exp_ratio(v, c) != 0) begin
        set_code(v, c);
        measure(v, n);
        chk(n == exp_ratio(v, c), req, n, exp_ratio(v, c));
      end
    end
  endtask

  task automatic test_tables_r3_r7;
    sweep_table(0, "R3 table 0");
    sweep_table(1, "R4 table 1");
    sweep_table(2, "R5 table 2");
    sweep_table(3, "R6 table 3");
    sweep_table(4, "R7 table 4");
    sweep_table(5, "R7 table 5");
  endtask

  task automatic test_illegal_r8;
    int n;
    int bad_codes[5] = '{0, 1, 2, 6, 9};
    set_code(2, 4);
    wait_tick(2);
    n = 0;
    @(negedge clk); n++;
    pulse_load(6); n++;
    chk(bads[2] == 1'b1, "R8 flag raised", int'(bads[2]), 1);
    @(negedge clk); n++;
    chk(bads[2] == 1'b0, "R8 flag one cycle", int'(bads[2]), 0);
    run_to_tick(2, n);
    chk(n == 5, "R8 period kept", n, 5);
    period(2, n);
    chk(n == 5, "R8 ratio kept", n, 5);
    foreach (bad_codes[i]) begin
      wait_tick(2);
      pulse_load(bad_codes[i]);
      chk(bads[2] == 1'b1, "R5/R8 illegal code flagged", int'(bads[2]), 1);
    end
    measure(2, n);
    chk(n == 5, "R8 ratio after illegal codes", n, 5);
    wait_tick(2);
    n = 0;
    @(negedge clk); n++;
    pulse_load(3); n++;
    pulse_load(0); n++;
    chk(bads[2] == 1'b1, "R8 flag after pending", int'(bads[2]), 1);
    run_to_tick(2, n);
    chk(n == 5, "R8 period with pending", n, 5);
    period(2, n);
    chk(n == 4, "R8 pending survives illegal", n, 4);
    pulse_load(20);
    chk(bads[4] == 1'b1, "R7/R8 illegal in table 4", int'(bads[4]), 1);
    chk(bads[5] == 1'b1, "R7/R8 illegal in table 5", int'(bads[5]), 1);
  endtask

  task automatic test_mid_period_r9;
    int n;
    set_code(3, 0);
    wait_tick(3);
    n = 0;
    @(negedge clk); n++;
    @(negedge clk); n++;
    pulse_load(7); n++;
    run_to_tick(3, n);
    chk(n == 9, "R9 current period kept", n, 9);
    period(3, n);
    chk(n == 18, "R9 new ratio next period", n, 18);
  endtask

  task automatic test_at_pulse_r10;
    int n;
    set_code(3, 7);
    wait_tick(3);
    n = 0;
    pulse_load(1); n++;
    run_to_tick(3, n);
    chk(n == 10, "R10 load at pulse", n, 10);
  endtask

  task automatic test_last_wins_r11;
    int n;
    set_code(3, 0);
    wait_tick(3);
    n = 0;
    @(negedge clk); n++;
    pulse_load(2); n++;
    pulse_load(5); n++;
    run_to_tick(3, n);
    chk(n == 9, "R11 period before switch", n, 9);
    period(3, n);
    chk(n == 14, "R11 last load wins", n, 14);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    print_summary();
    $finish;
  end

  initial begin
    test_reset_r1();
    test_width_r2();
    test_tables_r3_r7();
    test_illegal_r8();
    test_mid_period_r9();
    test_at_pulse_r10();
    test_last_wins_r11();
    print_summary();
    $finish;
  end
endmodule